// File: doc/BRIEF.md
# Configurable Logic Self-Test Engine

This block runs a built-in self-test on a combinational circuit. It drives pseudorandom stimulus into that circuit and folds every response into a signature register. After a fixed number of clock cycles it stops and reports the signature, which can be compared with a known-good value. The circuit under test sits outside the block. It takes `test_pattern` and returns `cut_resp` combinationally in the same cycle.

Two architectures are offered. In the split architecture, a generator register produces the patterns and a separate analyzer register compacts the responses. In the circular architecture, one register does both jobs: responses are XORed back into the same register that produces the next pattern.

Both registers can run in external-XOR or internal-XOR feedback form. Responses can be folded in at the high end or the low end of the compacting register. Polynomials, seeds, feedback form, alignment and test length are all set through a small write port while the engine is idle. A one-cycle `start` pulse then runs the test.

Top module: `lbist_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `test_pattern` and `signature` are 0. The configuration resets to all zeros, which selects the split architecture, external-XOR feedback, high-end alignment and the default length.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` at `cfg_addr`. The addresses are:
  - 0: control word. Bit 0 selects the circular architecture (1) instead of split (0). Bit 1 selects internal-XOR feedback (1) instead of external-XOR (0). Bit 2 selects low-end alignment (1) instead of high-end (0).
  - 1: generator polynomial.
  - 2: generator seed.
  - 3: analyzer polynomial.
  - 4: analyzer seed.
  - 5: test length.
- R3: External-XOR step of a register of width W: the register shifts one place toward the MSB. The new bit 0 is the XOR of all state bits i for which polynomial bit i is 1.
- R4: Internal-XOR step of a register of width W: the register shifts one place toward the MSB with 0 entering bit 0. If the old bit W-1 was 1, the polynomial is then XORed into the result.
- R5: Split architecture. `test_pattern` is the generator state. Each running cycle, the generator steps, and the analyzer steps and is XORed with the aligned response. `signature` is the analyzer state.
- R6: Circular architecture. Only the generator register runs. Each cycle its next value is its step XORed with the aligned response. `signature` is that register, zero-extended. The analyzer polynomial and seed have no effect.
- R7: The response alignment for a register of width W and response width RW is as follows. With high-end alignment and RW≤W, response bit j lands on register bit j+W-RW; with RW>W, the top W response bits are used. With low-end alignment, response bit j lands on bit j, and bits at or above W are dropped.
- R8: A test applies exactly N patterns. N is the programmed length, or 1000 if the length is 0. `done` rises N cycles after the cycle in which `start` was sampled.
- R9: Once the test ends, `done` stays high, and `signature` and `test_pattern` hold, until the next `start`.
- R10: While `busy` is high, configuration writes and `start` pulses are ignored.
- R11: A generator seed of 0 is replaced by 1. The first pattern is never all-zero.
- R12: In the cycle after `start` is sampled, `test_pattern` equals the effective generator seed, and `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | One-cycle pulse that starts a test |
| test_pattern | output | GEN_W | Stimulus to the circuit under test |
| cut_resp | input | RESP_W | Combinational response of the circuit under test |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished; signature valid |
| signature | output | SIG_W | Final compacted signature |

## Verification
The bench first exercises the defaults: a run that writes no control word and no length must select the split architecture, external-XOR feedback, high-end alignment and 1000 cycles. A design that got a default wrong would produce a wrong signature or a wrong cycle count. Response width differs from both register widths, so misplaced alignment or a swapped feedback form changes the signature.

Directed cases cover several boundaries:
- A zero generator seed. A design that failed to replace it would lock up, with an all-zero first pattern.
- A length of 1. An off-by-one counter would show up here.
- Configuration writes and a second `start` issued mid-run. A design that accepted them would alter the signature or restart the count.

Random configurations then sweep both architectures and both feedback forms.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic {
    ARCH_SPLIT    = 1'b0,
    ARCH_CIRCULAR = 1'b1
  } arch_e;

  typedef struct packed {
    arch_e       arch;
    logic        internal_xor;
    logic        low_align;
    logic [31:0] gen_poly;
    logic [31:0] gen_seed;
    logic [31:0] ana_poly;
    logic [31:0] ana_seed;
    logic [31:0] length;
  } cfg_t;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_GPOLY = 3'd1;
  localparam logic [2:0] A_GSEED = 3'd2;
  localparam logic [2:0] A_APOLY = 3'd3;
  localparam logic [2:0] A_ASEED = 3'd4;
  localparam logic [2:0] A_LEN   = 3'd5;

  function automatic logic [31:0] width_mask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] lfsr_next(input logic [31:0] s, input logic [31:0] poly,
                                            input int w, input logic internal_xor);
    logic [31:0] m;
    logic [31:0] r;
    m = width_mask(w);
    if (internal_xor)
      r = (s << 1) ^ (s[w-1] ? poly : 32'd0);
    else
      r = (s << 1) | {31'd0, ^(s & poly & m)};
    return r & m;
  endfunction

  function automatic logic [31:0] align_resp(input logic [31:0] resp, input int rw,
                                             input int w, input logic low_align);
    logic [31:0] r;
    if (low_align)    r = resp;
    else if (rw <= w) r = resp << (w - rw);
    else              r = resp >> (rw - w);
    return r & width_mask(w);
  endfunction

endpackage

// File: rtl/lbist_cfg.sv
module lbist_cfg
  import lbist_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        busy,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output cfg_t        cfg
);

  logic wr_ok;
  assign wr_ok = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_ok) begin
      case (cfg_addr)
        A_CTRL: begin
          cfg.arch         <= arch_e'(cfg_wdata[0]);
          cfg.internal_xor <= cfg_wdata[1];
          cfg.low_align    <= cfg_wdata[2];
        end
        A_GPOLY: cfg.gen_poly <= cfg_wdata;
        A_GSEED: cfg.gen_seed <= cfg_wdata;
        A_APOLY: cfg.ana_poly <= cfg_wdata;
        A_ASEED: cfg.ana_seed <= cfg_wdata;
        A_LEN:   cfg.length   <= cfg_wdata;
        default: ;
      endcase
    end
  end

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy && cfg_we |=> $stable(cfg));

endmodule

// File: rtl/lbist_seq.sv
module lbist_seq #(
  parameter int CNT_W   = 20,
  parameter int DEF_LEN = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len_cfg,
  output logic             load,
  output logic             step,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] DEF_N = CNT_W'(DEF_LEN);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = (len_cfg == '0) ? DEF_N : len_cfg;
  assign load  = start && !busy;
  assign step  = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == limit - 1'b1) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8
  end_raises_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R8
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < limit));
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> (done || busy));

endmodule

// File: rtl/lbist_lfsr.sv
module lbist_lfsr
  import lbist_pkg::*;
#(
  parameter int W  = 16,
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  seed,
  input  logic          step,
  input  logic [W-1:0]  poly,
  input  logic          internal_xor,
  input  logic          inj_en,
  input  logic          low_align,
  input  logic [RW-1:0] resp,
  output logic [W-1:0]  state
);

  logic [31:0] shifted;
  logic [31:0] folded;

  assign shifted = lfsr_next(32'(state), 32'(poly), W, internal_xor);
  assign folded  = inj_en ? align_resp(32'(resp), RW, W, low_align) : 32'd0;

  always_ff @(posedge clk) begin
    if (rst)       state <= '0;
    else if (load) state <= seed;
    else if (step) state <= W'(shifted ^ folded);
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !load && !step |=> $stable(state));

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int GEN_W   = 12,
  parameter int ANA_W   = 16,
  parameter int RESP_W  = 10,
  parameter int CNT_W   = 20,
  parameter int DEF_LEN = 1000,
  localparam int SIG_W  = (GEN_W > ANA_W) ? GEN_W : ANA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              start,
  output logic [GEN_W-1:0]  test_pattern,
  input  logic [RESP_W-1:0] cut_resp,
  output logic              busy,
  output logic              done,
  output logic [SIG_W-1:0]  signature
);

  cfg_t             cfg;
  logic             load;
  logic             step;
  arch_e            arch_run;
  logic [GEN_W-1:0] gen_seed_eff;
  logic [GEN_W-1:0] gen_q;
  logic [ANA_W-1:0] ana_q;
  logic             circ;

  lbist_cfg u_cfg (
    .clk(clk), .rst(rst), .busy(busy),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg(cfg)
  );

  lbist_seq #(.CNT_W(CNT_W), .DEF_LEN(DEF_LEN)) u_seq (
    .clk(clk), .rst(rst), .start(start), .len_cfg(cfg.length[CNT_W-1:0]),
    .load(load), .step(step), .busy(busy), .done(done)
  );

  // The architecture is latched at start so the result mux cannot move afterwards.
  always_ff @(posedge clk) begin
    if (rst)       arch_run <= ARCH_SPLIT;
    else if (load) arch_run <= cfg.arch;
  end

  assign circ         = (arch_run == ARCH_CIRCULAR);
  assign gen_seed_eff = (cfg.gen_seed[GEN_W-1:0] == '0) ? GEN_W'(1) : cfg.gen_seed[GEN_W-1:0];

  lbist_lfsr #(.W(GEN_W), .RW(RESP_W)) u_gen (
    .clk(clk), .rst(rst), .load(load), .seed(gen_seed_eff), .step(step),
    .poly(cfg.gen_poly[GEN_W-1:0]), .internal_xor(cfg.internal_xor),
    .inj_en(circ), .low_align(cfg.low_align), .resp(cut_resp), .state(gen_q)
  );

  lbist_lfsr #(.W(ANA_W), .RW(RESP_W)) u_ana (
    .clk(clk), .rst(rst), .load(load), .seed(cfg.ana_seed[ANA_W-1:0]),
    .step(step && !circ),
    .poly(cfg.ana_poly[ANA_W-1:0]), .internal_xor(cfg.internal_xor),
    .inj_en(1'b1), .low_align(cfg.low_align), .resp(cut_resp), .state(ana_q)
  );

  assign test_pattern = gen_q;
  assign signature    = circ ? SIG_W'(gen_q) : SIG_W'(ana_q);

  // R11
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (test_pattern != '0));
  // R12
  busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> busy && !done);
  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

endmodule

// File: tb/lbist_ctrl_tb.sv
module lbist_ctrl_tb;

  localparam int GEN_W  = 12;
  localparam int ANA_W  = 16;
  localparam int RESP_W = 10;
  localparam int SIG_W  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_we;
  logic [2:0]        cfg_addr;
  logic [31:0]       cfg_wdata;
  logic              start;
  logic [GEN_W-1:0]  test_pattern;
  logic [RESP_W-1:0] cut_resp;
  logic              busy;
  logic              done;
  logic [SIG_W-1:0]  signature;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  function automatic logic [RESP_W-1:0] cut_fn(input logic [GEN_W-1:0] p);
    logic [31:0] t;
    t = (32'(p) * 32'd7) ^ (32'(p) >> 3) ^ 32'h2A5;
    return t[RESP_W-1:0];
  endfunction

  assign cut_resp = cut_fn(test_pattern);

  lbist_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .test_pattern(test_pattern), .cut_resp(cut_resp),
    .busy(busy), .done(done), .signature(signature)
  );

  function automatic logic [31:0] m_step(input logic [31:0] s, input logic [31:0] p,
                                         input int w, input bit md);
    logic [31:0] n;
    logic fb;
    n = '0;
    fb = 1'b0;
    for (int i = 0; i < w; i++) begin
      if (md) n[i] = ((i == 0) ? 1'b0 : s[i-1]) ^ (s[w-1] & p[i]);
      else begin
        fb = fb ^ (s[i] & p[i]);
        if (i > 0) n[i] = s[i-1];
      end
    end
    if (!md) n[0] = fb;
    return n;
  endfunction

  function automatic logic [31:0] m_inj(input logic [31:0] r, input int w, input bit lsb);
    logic [31:0] n;
    int src;
    n = '0;
    for (int i = 0; i < w; i++) begin
      if (lsb) src = i;
      else if (RESP_W <= w) src = i - (w - RESP_W);
      else src = i + (RESP_W - w);
      if (src >= 0 && src < RESP_W) n[i] = r[src];
    end
    return n;
  endfunction

  function automatic logic [31:0] model_sig(input bit circ, input bit md, input bit lsb,
      input logic [31:0] gp, input logic [31:0] gs, input logic [31:0] ap,
      input logic [31:0] as_, input int n);
    logic [31:0] g, a, r;
    logic [31:0] gm, am;
    gm = (32'd1 << GEN_W) - 1;
    am = (32'd1 << ANA_W) - 1;
    g = gs & gm;
    if (g == 0) g = 1;
    a = as_ & am;
    for (int k = 0; k < n; k++) begin
      r = 32'(cut_fn(g[GEN_W-1:0]));
      if (circ) g = m_step(g, gp & gm, GEN_W, md) ^ m_inj(r, GEN_W, lsb);
      else begin
        a = m_step(a, ap & am, ANA_W, md) ^ m_inj(r, ANA_W, lsb);
        g = m_step(g, gp & gm, GEN_W, md);
      end
    end
    return circ ? g : a;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Run one test. If interfere is set, mid-run writes and a start are issued (R10).
  task automatic run(input string tag, input bit write_ctrl, input bit circ, input bit md,
                     input bit lsb, input logic [31:0] gp, input logic [31:0] gs,
                     input logic [31:0] ap, input logic [31:0] as_, input int len,
                     input bit write_len, input bit interfere);
    int n, cyc;
    logic [31:0] exp, seed_eff;
    logic [SIG_W-1:0] held;
    logic [GEN_W-1:0] pat_held;
    if (write_ctrl) wr(3'd0, {29'd0, lsb, md, circ});
    wr(3'd1, gp); wr(3'd2, gs); wr(3'd3, ap); wr(3'd4, as_);
    if (write_len) wr(3'd5, len);
    n = (len == 0) ? 1000 : len;
    exp = model_sig(circ, md, lsb, gp, gs, ap, as_, n);
    seed_eff = gs & ((32'd1 << GEN_W) - 1);
    if (seed_eff == 0) seed_eff = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R12 / R11: first pattern is the effective seed
    check({tag, " R12 first pattern"}, 32'(test_pattern), seed_eff);
    check({tag, " R12 busy"}, 32'(busy), 32'd1);
    cyc = 0;
    if (interfere) begin
      cfg_we = 1'b1;
      for (int a = 0; a < 6; a++) begin
        cfg_addr = 3'(a); cfg_wdata = 32'hA5A5_5A5A ^ 32'(a);
        @(negedge clk); cyc++;
        if (a == 2) start = 1'b1; else start = 1'b0;
      end
      cfg_we = 1'b0; start = 1'b0;
    end
    while (!done && cyc < 5000) begin
      @(negedge clk); cyc++;
    end
    // R8 test length
    check({tag, " R8 cycles"}, 32'(cyc), 32'(n));
    // R5 / R6 / R3 / R4 / R7 signature
    check({tag, " R5 R6 signature"}, 32'(signature), exp);
    held = signature; pat_held = test_pattern;
    repeat (4) @(negedge clk);
    // R9 hold after end
    check({tag, " R9 done held"}, 32'(done), 32'd1);
    check({tag, " R9 signature held"}, 32'(signature), 32'(held));
    check({tag, " R9 pattern held"}, 32'(test_pattern), 32'(pat_held));
    if (interfere) begin
      // R10: rerun without rewriting; mid-run writes must not have landed
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cyc = 0;
      while (!done && cyc < 5000) begin
        @(negedge clk); cyc++;
      end
      check({tag, " R10 rerun cycles"}, 32'(cyc), 32'(n));
      check({tag, " R10 rerun signature"}, 32'(signature), exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; start = 1'b0;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 pattern", 32'(test_pattern), 32'd0);
    check("R1 signature", 32'(signature), 32'd0);
    // R1 / R8 defaults: split, external XOR, high-end alignment, 1000 cycles
    run("default", 1'b0, 1'b0, 1'b0, 1'b0, 32'h0C1, 32'h5A3, 32'hB400, 32'h1234, 0, 1'b0, 1'b0);
    // R2 R4 R7: circular, internal XOR, low alignment
    run("circ_mod_lsb", 1'b1, 1'b1, 1'b1, 1'b1, 32'h829, 32'h3C7, 32'h0, 32'h0, 37, 1'b1, 1'b0);
    // R6 R3 R7: circular, external XOR, high alignment
    run("circ_std_msb", 1'b1, 1'b1, 1'b0, 1'b0, 32'hC11, 32'h001, 32'hFFFF, 32'hFFFF, 23, 1'b1, 1'b0);
    // R5 R4 R7: split, internal XOR, low alignment
    run("split_mod_lsb", 1'b1, 1'b0, 1'b1, 1'b1, 32'h053, 32'h7E1, 32'h100B, 32'h8001, 41, 1'b1, 1'b0);
    // R11 zero generator seed
    run("zero_seed", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0C1, 32'h000, 32'hB400, 32'h0, 15, 1'b1, 1'b0);
    // R8 length of one
    run("len_one", 1'b1, 1'b0, 1'b1, 1'b0, 32'h0C1, 32'h123, 32'hB400, 32'h0F0F, 1, 1'b1, 1'b0);
    // R10 interference during run
    run("interfere", 1'b1, 1'b0, 1'b0, 1'b1, 32'h0C1, 32'h2B7, 32'hB400, 32'h4321, 30, 1'b1, 1'b1);
    // random sweep (R3 R4 R5 R6 R7)
    for (int t = 0; t < 12; t++) begin
      logic [31:0] ctl;
      ctl = $urandom;
      run("random", 1'b1, ctl[0], ctl[1], ctl[2], $urandom, $urandom, $urandom, $urandom,
          int'($urandom_range(2, 80)), 1'b1, ctl[3]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule